// File: doc/BRIEF.md
# Latched Masked Interrupt Status Register

This block holds the interrupt state for two system-control event sources: the PLL lock timer reporting that the clock is ready, and the brown-out detector. A rising edge on an event input sets a raw status bit. A raw bit that is set while its enable bit in the mask register is high latches a masked status bit. That masked bit stays set until software clears it, even if the mask is dropped afterwards. The block drives a single interrupt line, which is the registered OR of the masked status bits.

Software reaches the three registers through a synchronous strobe port. A write of 1 to a masked status bit clears that bit and also clears the matching raw bit. When an event edge arrives in the same cycle as the clear, the event wins and the raw bit remains set. Each source is tracked by a small state machine. The states are `ST_IDLE` (nothing recorded), `ST_RAW` (raw set, masked clear) and `ST_PEND` (raw and masked both set). The transitions are:

- ST_IDLE goes to ST_RAW on an edge.
- ST_RAW goes to ST_PEND when the mask is high and no clear occurs.
- ST_RAW or ST_PEND goes to ST_IDLE on a clear without an edge.
- ST_RAW or ST_PEND goes to ST_RAW on a clear together with an edge.
- Otherwise each state holds.

Top module: `sysctl_irq_status`

## Requirements
- R1: After reset, all three registers read 0, `irq` is 0 and `bus_rdata` is 0.
- R2: The registers sit at byte offsets 0x050 (raw status, read-only), 0x054 (mask) and 0x058 (masked status, write-one-to-clear). In every register, bit 6 belongs to the PLL-ready source and bit 1 belongs to the brown-out source.
- R3: A 0-to-1 transition on an event input, sampled at a clock edge, sets its raw bit at that edge. The bit stays set while the input is held high. Holding the input high does not set the bit again after a clear.
- R4: The mask register stores bits 6 and 1 as written. Its other bits read 0.
- R5: A masked status bit sets at the clock edge after the edge at which its raw bit and its mask bit are both 1.
- R6: Once a masked status bit is set, clearing the mask bit does not clear it.
- R7: Writing 1 to bit 6 or bit 1 at 0x058 clears that masked bit and its raw bit at the same edge. Writing 0 there changes nothing.
- R8: If an event edge coincides with a clear of the same bit, the raw bit stays 1 and the masked bit clears. The masked bit sets again one edge later if the mask bit is 1.
- R9: Reserved bits of all three registers read 0, and writes to them have no effect. Writes to the raw status register change nothing.
- R10: `irq` equals the OR of the masked status bits as they stood one clock earlier.
- R11: A read of an unmapped or misaligned address (low two bits not 00) returns 0. A write to such an address changes no register.
- R12: `bus_rdata` shows the addressed register, as it stood before the edge, one cycle after `bus_rd`. It is 0 in any cycle that follows one without `bus_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_pll_ready | input | 1 | PLL lock timer ready event |
| evt_brownout | input | 1 | Brown-out detector event |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Registered interrupt request |

## Verification
The main function is exercised with single-cycle event pulses, with an event level held high across a clear, and with a pulse that falls in exactly the cycle of a clear. Pulses separate edge capture from level capture. The held level shows whether the block wrongly re-arms on a level. The coincident case shows whether set or clear has priority. Mask writes are made both before and after an event, and the mask is cleared while the status is latched. This tells a sticky latch apart from a plain combinational AND. A behavioural model in the bench predicts `irq` and `bus_rdata` on every clock.

// File: rtl/sc_irq_pkg.sv
package sc_irq_pkg;

    // Number of event sources handled by the block
    localparam int NUM_SRC = 2;

    // Byte offsets of the three registers
    localparam int OFS_RAW  = 'h050;
    localparam int OFS_MASK = 'h054;
    localparam int OFS_STAT = 'h058;

    // Per-source state
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RAW  = 2'd1,
        ST_PEND = 2'd2
    } src_state_e;

    // Register bit position that carries source idx (0: PLL ready, 1: brown-out)
    function automatic int src_bit(input int idx);
        return (idx == 0) ? 6 : 1;
    endfunction

endpackage

// File: rtl/sc_irq_edge.sv
module sc_irq_edge #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    output logic [W-1:0] rise_o
);

    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= evt_i;
    end

    assign rise_o = evt_i & ~prev_q;

endmodule

// File: rtl/sc_irq_cell.sv
module sc_irq_cell
    import sc_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt_rise,
    input  logic sw_clr,
    input  logic mask_en,
    output logic raw_o,
    output logic mis_o
);

    src_state_e st_q, st_nx;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_nx;
    end

    // Next state: an event edge always wins over a software clear
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (evt_rise) st_nx = ST_RAW;
            end
            ST_RAW: begin
                if (sw_clr)       st_nx = evt_rise ? ST_RAW : ST_IDLE;
                else if (mask_en) st_nx = ST_PEND;
            end
            ST_PEND: begin
                if (sw_clr) st_nx = evt_rise ? ST_RAW : ST_IDLE;
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        raw_o = (st_q != ST_IDLE);
        mis_o = (st_q == ST_PEND);
    end

    AST_EDGE_SETS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        evt_rise |=> raw_o); // R8
    AST_CLEAR_DROPS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_clr && !evt_rise) |=> (!raw_o && !mis_o)); // R7
    AST_MIS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (mis_o && !sw_clr) |=> mis_o); // R6
    AST_MIS_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_o && mask_en && !sw_clr) |=> mis_o); // R5

endmodule

// File: rtl/sc_irq_regfile.sv
module sc_irq_regfile
    import sc_irq_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic               bus_rd,
    input  logic [NUM_SRC-1:0] raw_vec,
    input  logic [NUM_SRC-1:0] mis_vec,
    output logic [NUM_SRC-1:0] mask_vec,
    output logic [NUM_SRC-1:0] clr_vec,
    output logic [DATA_W-1:0]  bus_rdata
);

    localparam logic [ADDR_W-1:0] A_RAW  = ADDR_W'(OFS_RAW);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);

    logic              aligned, hit_raw, hit_mask, hit_stat, hit_any;
    logic [NUM_SRC-1:0] mask_q;
    logic [DATA_W-1:0]  raw_w, mask_w, stat_w, rd_val;
    logic               wdata_unused;

    assign aligned  = (bus_addr[1:0] == 2'b00);
    assign hit_raw  = aligned && (bus_addr == A_RAW);
    assign hit_mask = aligned && (bus_addr == A_MASK);
    assign hit_stat = aligned && (bus_addr == A_STAT);
    assign hit_any  = hit_raw || hit_mask || hit_stat;
    assign wdata_unused = ^bus_wdata;

    // Mask register and clear strobes, one bit per source
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (bus_wr && hit_mask) begin
            for (int i = 0; i < NUM_SRC; i++) mask_q[i] <= bus_wdata[src_bit(i)];
        end
    end

    always_comb begin
        for (int i = 0; i < NUM_SRC; i++)
            clr_vec[i] = bus_wr && hit_stat && bus_wdata[src_bit(i)];
    end

    assign mask_vec = mask_q;

    // Word assembly: only the implemented positions carry state
    always_comb begin
        raw_w  = '0;
        mask_w = '0;
        stat_w = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            raw_w[src_bit(i)]  = raw_vec[i];
            mask_w[src_bit(i)] = mask_q[i];
            stat_w[src_bit(i)] = mis_vec[i];
        end
    end

    always_comb begin
        rd_val = '0;
        if (hit_raw)       rd_val = raw_w;
        else if (hit_mask) rd_val = mask_w;
        else if (hit_stat) rd_val = stat_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_val;
        else             bus_rdata <= '0;
    end

    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0)); // R12
    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !hit_any) |=> (bus_rdata == '0)); // R11
    AST_MASK_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && hit_mask) |=> (mask_q[0] == $past(bus_wdata[src_bit(0)]))); // R4

endmodule

// File: rtl/sysctl_irq_status.sv
module sysctl_irq_status
    import sc_irq_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_pll_ready,
    input  logic              evt_brownout,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    logic [NUM_SRC-1:0] evt_vec, rise_vec, raw_vec, mis_vec, mask_vec, clr_vec;

    // Source index 0 is the PLL-ready event, index 1 the brown-out event
    assign evt_vec = {evt_brownout, evt_pll_ready};

    sc_irq_edge #(.W(NUM_SRC)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt_vec),
        .rise_o (rise_vec)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        sc_irq_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .evt_rise (rise_vec[g]),
            .sw_clr   (clr_vec[g]),
            .mask_en  (mask_vec[g]),
            .raw_o    (raw_vec[g]),
            .mis_o    (mis_vec[g])
        );
    end

    sc_irq_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .raw_vec   (raw_vec),
        .mis_vec   (mis_vec),
        .mask_vec  (mask_vec),
        .clr_vec   (clr_vec),
        .bus_rdata (bus_rdata)
    );

    // Interrupt line: registered OR of the latched masked bits
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |mis_vec;
    end

    AST_IRQ_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        (|mis_vec) |=> irq); // R10
    AST_IRQ_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        !(|mis_vec) |=> !irq); // R10

endmodule

// File: tb/sim_sysctl_irq_status.sv
module sim_sysctl_irq_status;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_pll_ready = 1'b0;
    logic        evt_brownout = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_P/2) clk = ~clk;

    sysctl_irq_status u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .evt_pll_ready (evt_pll_ready),
        .evt_brownout  (evt_brownout),
        .bus_addr      (bus_addr),
        .bus_wr        (bus_wr),
        .bus_wdata     (bus_wdata),
        .bus_rd        (bus_rd),
        .bus_rdata     (bus_rdata),
        .irq           (irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural reference model, updated on every rising edge
    logic [31:0] m_raw = '0, m_mask = '0, m_mis = '0, m_rdata = '0;
    logic        m_irq = 1'b0, p_pll = 1'b0, p_bo = 1'b0;

    always @(posedge clk) begin
        logic [31:0] e_w, clr_w, rv;
        if (!rst_n) begin
            m_raw = '0; m_mask = '0; m_mis = '0; m_rdata = '0;
            m_irq = 1'b0; p_pll = 1'b0; p_bo = 1'b0;
        end else begin
            e_w = '0;
            e_w[6] = evt_pll_ready && !p_pll;
            e_w[1] = evt_brownout && !p_bo;
            p_pll = evt_pll_ready;
            p_bo  = evt_brownout;
            clr_w = (bus_wr && bus_addr == 12'h058) ? (bus_wdata & 32'h42) : 32'h0;
            rv = 32'h0;
            if (bus_addr == 12'h050) rv = m_raw;
            if (bus_addr == 12'h054) rv = m_mask;
            if (bus_addr == 12'h058) rv = m_mis;
            m_rdata = bus_rd ? rv : 32'h0;
            m_irq   = (m_mis != 0);
            m_mis   = (m_mis | (m_raw & m_mask)) & ~clr_w;
            m_raw   = (m_raw & ~clr_w) | e_w;
            if (bus_wr && bus_addr == 12'h054) m_mask = bus_wdata & 32'h42;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R10 irq vs model", {31'h0, irq}, {31'h0, m_irq});
            chk("R12 rdata vs model", bus_rdata, m_rdata);
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic summary;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_P * 50000);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 irq after reset", {31'h0, irq}, 32'h0);
        chk("R1 rdata after reset", bus_rdata, 32'h0);
        rd_chk(12'h050, 32'h0, "R1 raw reset");
        rd_chk(12'h054, 32'h0, "R1 mask reset");
        rd_chk(12'h058, 32'h0, "R1 status reset");

        // R4, R9: mask stores only implemented bits
        wr(12'h054, 32'hFFFF_FFFF);
        rd_chk(12'h054, 32'h0000_0042, "R4 R9 mask readback");
        wr(12'h054, 32'h0);

        // R3, R2: PLL pulse sets raw bit 6, masked off
        evt_pll_ready = 1'b1; idle(1); evt_pll_ready = 1'b0; idle(1);
        rd_chk(12'h050, 32'h0000_0040, "R3 R2 raw after pll pulse");
        rd_chk(12'h058, 32'h0, "R5 status stays clear while masked");
        chk("R10 irq low while masked", {31'h0, irq}, 32'h0);

        // R5, R10: enable mask after the event
        wr(12'h054, 32'h0000_0040); idle(2);
        rd_chk(12'h058, 32'h0000_0040, "R5 status latches");
        chk("R10 irq asserted", {31'h0, irq}, 32'h1);

        // R6: dropping mask keeps the latch
        wr(12'h054, 32'h0); idle(2);
        rd_chk(12'h058, 32'h0000_0040, "R6 status sticky");

        // R7, R9: zero writes and raw writes do nothing
        wr(12'h058, 32'h0); idle(1);
        rd_chk(12'h058, 32'h0000_0040, "R7 write zero no effect");
        wr(12'h050, 32'h0); idle(1);
        rd_chk(12'h050, 32'h0000_0040, "R9 raw write ignored");

        // R7: W1C clears status and raw
        wr(12'h058, 32'hFFFF_FFFF); idle(2);
        rd_chk(12'h058, 32'h0, "R7 status cleared");
        rd_chk(12'h050, 32'h0, "R7 raw cleared");
        chk("R10 irq deasserted", {31'h0, irq}, 32'h0);

        // R3: brown-out level held across a clear does not re-arm
        wr(12'h054, 32'h0000_0002);
        evt_brownout = 1'b1; idle(3);
        rd_chk(12'h050, 32'h0000_0002, "R3 R2 raw brown-out");
        rd_chk(12'h058, 32'h0000_0002, "R5 status brown-out");
        wr(12'h058, 32'h0000_0002); idle(2);
        rd_chk(12'h050, 32'h0, "R3 level does not retrigger");
        rd_chk(12'h058, 32'h0, "R7 brown-out status cleared");
        evt_brownout = 1'b0; idle(1);

        // R8: edge coinciding with clear keeps the event
        wr(12'h054, 32'h0000_0040);
        evt_pll_ready = 1'b1; idle(1); evt_pll_ready = 1'b0; idle(2);
        rd_chk(12'h058, 32'h0000_0040, "R8 status before clash");
        bus_addr = 12'h058; bus_wdata = 32'h0000_0040; bus_wr = 1'b1; evt_pll_ready = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0; evt_pll_ready = 1'b0;
        rd_chk(12'h050, 32'h0000_0040, "R8 raw kept on clash");
        rd_chk(12'h058, 32'h0000_0040, "R8 status relatches");

        // R11: unmapped and misaligned accesses
        wr(12'h05C, 32'hFFFF_FFFF);
        wr(12'h059, 32'hFFFF_FFFF); idle(1);
        rd_chk(12'h05C, 32'h0, "R11 unmapped read");
        rd_chk(12'h000, 32'h0, "R11 unmapped read low");
        rd_chk(12'h059, 32'h0, "R11 misaligned read");
        rd_chk(12'h058, 32'h0000_0040, "R11 status untouched");
        rd_chk(12'h054, 32'h0000_0040, "R11 mask untouched");

        // R12: idle bus gives zero data
        idle(2);
        chk("R12 rdata idle", bus_rdata, 32'h0);
        summary();
    end

endmodule